// File: doc/BRIEF.md
# Shield Configuration Sweep and Averaging Controller

This controller runs a complete measurement campaign over a reconfigurable four-stage ring oscillator. Each stage picks one of four shield spacings through its own 2-bit select. The controller walks all 256 path configurations in index order. For each configuration it drives the 8-bit select word and sets the window select to the longest aperture. It then runs fifty window measurements through a start/done handshake with an external pulse counter, and sums the returned counts.

After the fiftieth count, a sequential divider forms the rounded mean of the counts. The mean is offered on a valid/ready result stream, tagged with the configuration index. The output-tap select follows the stage 0 select bits, so the observed tap always belongs to the configuration under test. When index 255 has been accepted, a sweep-complete flag rises and the controller waits for the next go pulse.

The states are IDLE, SETTLE, START, WAIT, DIVIDE and EMIT:

- IDLE moves to SETTLE on go.
- SETTLE always moves to START. This gives one idle cycle with a stable select word.
- START issues the one-cycle start pulse and moves to WAIT.
- WAIT moves on a done pulse. After the fiftieth done it goes to DIVIDE; before that it goes back to SETTLE.
- DIVIDE moves to EMIT when the divider finishes.
- EMIT moves on ready. After the last index it goes to IDLE; otherwise it goes to SETTLE with the next index.

Top module: `sweep_avg_ctrl`

## Requirements
- R1: After reset `meas_start_o`, `res_valid_o` and `sweep_done_o` are 0 and `sel_o` is 0.
- R2: A go pulse in IDLE starts a sweep at index 0; go pulses while a sweep is running have no effect on the index order.
- R3: `sel_o` equals the configuration index, with stage j driven by bits [2j+1:2j]; `tap_o` always equals `sel_o[1:0]`.
- R4: `sel_o` is unchanged for at least one cycle before each start pulse and stays unchanged until the matching done.
- R5: `win_sel_o` is 3 at every start pulse. The codes 0 to 3 choose apertures of 200, 240, 280 and 320 ns, so code 3 is the longest.
- R6: Each configuration receives exactly 50 measurements. A start pulse lasts one cycle, and no new start is issued before the previous done.
- R7: The reported average is floor((sum of the 50 counts + 25) / 50), so an exact half rounds up.
- R8: Results appear in index order 0 to 255, each index exactly once per sweep.
- R9: While `res_valid_o` is high and `res_ready_i` is low, valid, index and average hold, and no measurement starts.
- R10: `sweep_done_o` rises once index 255 is accepted and stays high with no further starts until go. A go pulse clears it and restarts the sweep at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Starts a sweep when idle |
| meas_start_o | output | 1 | One-cycle request to open a counting window |
| meas_done_i | input | 1 | Counter reports its window closed |
| meas_count_i | input | 10 | Pulse count of the closed window, valid with done |
| sel_o | output | 8 | Ring path select word, 2 bits per stage |
| tap_o | output | 2 | Output tap select (stage 0 select) |
| win_sel_o | output | 2 | Window length code |
| res_valid_o | output | 1 | Result beat valid |
| res_ready_i | input | 1 | Result beat accepted |
| res_index_o | output | 8 | Configuration index of the result |
| res_avg_o | output | 10 | Rounded mean count |
| sweep_done_o | output | 1 | All 256 configurations reported |

## Verification
The assertions assume that the counter returns exactly one done pulse per start, never before the cycle after the start, and never while idle. The bench's counter model meets this by answering each start after one to three cycles. The assertions also assume that the count is no larger than 1023 and that ready may drop at any time. The bench model stays within 10 bits, and the bench holds ready low for a long stretch and releases it only while a beat is pending.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_START,
        ST_WAIT,
        ST_DIVIDE,
        ST_EMIT
    } sweep_state_t;
endpackage

// File: rtl/avg_div.sv
// Restoring divider by a constant; one quotient bit per cycle.
module avg_div #(
    parameter int W   = 16,
    parameter int QW  = 10,
    parameter int DIV = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  dividend_i,
    output logic          done_o,
    output logic [QW-1:0] quot_o
);
    localparam int CW = $clog2(W);
    localparam logic [W:0] DIV_V = (W+1)'(DIV);

    logic [W-1:0]  dvd_q, quo_q, rem_q, saved_q;
    logic [CW-1:0] step_q;
    logic          busy_q;
    logic [W:0]    shifted;
    logic          ge;

    always_comb begin
        shifted = {rem_q, dvd_q[W-1]};
        ge      = (shifted >= DIV_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            saved_q <= '0;
            step_q  <= '0;
            busy_q  <= 1'b0;
            done_o  <= 1'b0;
        end else if (start_i) begin
            dvd_q   <= dividend_i;
            saved_q <= dividend_i;
            quo_q   <= '0;
            rem_q   <= '0;
            step_q  <= '0;
            busy_q  <= 1'b1;
            done_o  <= 1'b0;
        end else if (busy_q) begin
            dvd_q  <= dvd_q << 1;
            quo_q  <= {quo_q[W-2:0], ge};
            rem_q  <= ge ? W'(shifted - DIV_V) : shifted[W-1:0];
            step_q <= step_q + 1'b1;
            if (step_q == CW'(W-1)) begin
                busy_q <= 1'b0;
                done_o <= 1'b1;
            end
        end else begin
            done_o <= 1'b0;
        end
    end

    assign quot_o = quo_q[QW-1:0];

    // R7: quotient and remainder reproduce the latched dividend
    assert_div_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((32'(quo_q) * 32'(DIV) + 32'(rem_q)) == 32'(saved_q)) && (32'(rem_q) < 32'(DIV)));
endmodule

// File: rtl/sweep_avg_ctrl.sv
module sweep_avg_ctrl
    import sweep_pkg::*;
#(
    parameter int NUM_STAGES    = 4,
    parameter int STAGE_SEL_W   = 2,
    parameter int REPS          = 50,
    parameter int CNT_W         = 10,
    parameter int ACC_W         = 16,
    parameter int WIN_W         = 2,
    parameter logic [1:0] LONG_WIN = 2'd3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                go_i,
    output logic                                meas_start_o,
    input  logic                                meas_done_i,
    input  logic [CNT_W-1:0]                    meas_count_i,
    output logic [NUM_STAGES*STAGE_SEL_W-1:0]   sel_o,
    output logic [STAGE_SEL_W-1:0]              tap_o,
    output logic [WIN_W-1:0]                    win_sel_o,
    output logic                                res_valid_o,
    input  logic                                res_ready_i,
    output logic [NUM_STAGES*STAGE_SEL_W-1:0]   res_index_o,
    output logic [CNT_W-1:0]                    res_avg_o,
    output logic                                sweep_done_o
);
    localparam int SEL_W = NUM_STAGES * STAGE_SEL_W;
    localparam int REP_W = $clog2(REPS);
    localparam int HALF  = REPS / 2;

    sweep_state_t        state_q, state_n;
    logic [SEL_W-1:0]    idx_q;
    logic [REP_W-1:0]    rep_q;
    logic [ACC_W-1:0]    acc_q, acc_sum, div_in;
    logic [CNT_W-1:0]    avg_q, quot;
    logic                sweep_done_q, last_rep, last_idx, div_start, div_done;

    assign last_rep  = (rep_q == REP_W'(REPS-1));
    assign last_idx  = (idx_q == '1);
    assign acc_sum   = acc_q + ACC_W'(meas_count_i);
    assign div_in    = acc_sum + ACC_W'(HALF);
    assign div_start = (state_q == ST_WAIT) && meas_done_i && last_rep;

    avg_div #(.W(ACC_W), .QW(CNT_W), .DIV(REPS)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_in),
        .done_o     (div_done),
        .quot_o     (quot)
    );

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (go_i) state_n = ST_SETTLE;
            ST_SETTLE: state_n = ST_START;
            ST_START:  state_n = ST_WAIT;
            ST_WAIT:   if (meas_done_i) state_n = last_rep ? ST_DIVIDE : ST_SETTLE;
            ST_DIVIDE: if (div_done) state_n = ST_EMIT;
            ST_EMIT:   if (res_ready_i) state_n = last_idx ? ST_IDLE : ST_SETTLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q        <= '0;
            rep_q        <= '0;
            acc_q        <= '0;
            avg_q        <= '0;
            sweep_done_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go_i) begin
                    idx_q        <= '0;
                    rep_q        <= '0;
                    acc_q        <= '0;
                    sweep_done_q <= 1'b0;
                end
                ST_WAIT: if (meas_done_i) begin
                    acc_q <= acc_sum;
                    rep_q <= last_rep ? '0 : rep_q + 1'b1;
                end
                ST_DIVIDE: if (div_done) avg_q <= quot;
                ST_EMIT: if (res_ready_i) begin
                    acc_q <= '0;
                    rep_q <= '0;
                    if (last_idx) sweep_done_q <= 1'b1;
                    else          idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        meas_start_o = (state_q == ST_START);
        res_valid_o  = (state_q == ST_EMIT);
        sel_o        = idx_q;
        tap_o        = idx_q[STAGE_SEL_W-1:0];
        win_sel_o    = WIN_W'(LONG_WIN);
        res_index_o  = idx_q;
        res_avg_o    = avg_q;
        sweep_done_o = sweep_done_q;
    end

    // R6: start lasts one cycle
    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start_o |=> !meas_start_o);
    // R4: select settled before start and held during the window
    assert_sel_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start_o |-> $stable(sel_o));
    assert_sel_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> $stable(sel_o));
    // R9: stalled beat holds
    assert_beat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_index_o) && $stable(res_avg_o)));
    // R10: completion follows acceptance of the last index
    assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweep_done_o) |-> $past(res_valid_o && res_ready_i && (res_index_o == '1)));
endmodule

// File: tb/sweep_avg_ctrl_tb.sv
module sweep_avg_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_i = 1'b0;
    logic       meas_start_o, meas_done_i = 1'b0;
    logic [9:0] meas_count_i = '0;
    logic [7:0] sel_o, res_index_o;
    logic [1:0] tap_o, win_sel_o;
    logic       res_valid_o, res_ready_i = 1'b1, sweep_done_o;
    logic [9:0] res_avg_o;

    int n_checks = 0, n_fail = 0;
    int mode = 0;
    int exp_idx = 0, n_results = 0, starts_cfg = 0, n_starts = 0;
    int resp_rep = 0, lat = 0, outstanding = 0;
    logic [7:0] prev_sel = '0, start_sel = '0;

    always #2 clk = ~clk;

    sweep_avg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .go_i(go_i),
        .meas_start_o(meas_start_o), .meas_done_i(meas_done_i), .meas_count_i(meas_count_i),
        .sel_o(sel_o), .tap_o(tap_o), .win_sel_o(win_sel_o),
        .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
        .res_index_o(res_index_o), .res_avg_o(res_avg_o), .sweep_done_o(sweep_done_o)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cnt_of(int m, int idx, int rep);
        if (m == 0) return (idx * 37 + rep * 13) % 1024;
        if (m == 1) return 1023;
        if (idx == 0) return (rep < 25) ? 1 : 0;
        if (idx == 1) return (rep < 24) ? 1 : 0;
        return (rep < 26) ? 1 : 0;
    endfunction

    function automatic int exp_avg(int m, int idx);
        int s = 0;
        for (int r = 0; r < 50; r++) s += cnt_of(m, idx, r);
        return (s + 25) / 50;
    endfunction

    // counter model and monitors, all at the falling edge
    always @(negedge clk) begin
        meas_done_i = 1'b0;
        if (!rst_n) begin
            lat = 0; outstanding = 0;
        end else begin
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    check(sel_o == start_sel, "R4 sel held to done", sel_o, start_sel);
                    meas_done_i  = 1'b1;
                    meas_count_i = 10'(cnt_of(mode, start_sel, resp_rep));
                    resp_rep++;
                    outstanding = 0;
                end
            end
            if (meas_start_o) begin
                n_starts++; starts_cfg++;
                check(outstanding == 0, "R6 start before done", outstanding, 0);
                check(sel_o == prev_sel, "R4 sel settled before start", sel_o, prev_sel);
                check(win_sel_o == 2'd3, "R5 window code", win_sel_o, 3);
                check(tap_o == sel_o[1:0], "R3 tap follows stage 0", tap_o, sel_o[1:0]);
                start_sel = sel_o;
                outstanding = 1;
                lat = 1 + (n_starts % 3);
            end
            if (res_valid_o && res_ready_i) begin
                check(res_index_o == 8'(exp_idx), "R8 index order", res_index_o, exp_idx);
                check(sel_o == res_index_o, "R3 sel equals index", sel_o, res_index_o);
                check(res_avg_o == 10'(exp_avg(mode, res_index_o)), "R7 average",
                      res_avg_o, exp_avg(mode, res_index_o));
                check(starts_cfg == 50, "R6 measurements per config", starts_cfg, 50);
                exp_idx++; n_results++; starts_cfg = 0; resp_rep = 0;
            end
            prev_sel = sel_o;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_idx = 0; n_results = 0; starts_cfg = 0; resp_rep = 0;
    endtask

    task automatic pulse_go();
        go_i = 1'b1; @(negedge clk); go_i = 1'b0;
    endtask

    task automatic wait_results(int n);
        int guard = 0;
        while (n_results < n && guard < 100000) begin @(negedge clk); guard++; end
        check(n_results >= n, "R8 results arrive", n_results, n);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(meas_start_o == 0, "R1 start idle", meas_start_o, 0);
        check(res_valid_o == 0, "R1 valid idle", res_valid_o, 0);
        check(sweep_done_o == 0, "R1 done idle", sweep_done_o, 0);
        check(sel_o == 0, "R1 sel zero", sel_o, 0);
    endtask

    task automatic t_full_sweep();
        int s0;
        mode = 0; res_ready_i = 1'b1;
        pulse_go();
        wait_results(10);
        pulse_go();                       // R2: ignored mid-sweep
        wait_results(256);
        repeat (3) @(negedge clk);
        check(sweep_done_o == 1, "R10 done raised", sweep_done_o, 1);
        check(exp_idx == 256, "R8 all indices", exp_idx, 256);
        s0 = n_starts;
        repeat (50) @(negedge clk);
        check(n_starts == s0, "R10 no starts after done", n_starts, s0);
        check(sweep_done_o == 1, "R10 done held", sweep_done_o, 1);
    endtask

    task automatic t_restart_max();
        mode = 1; exp_idx = 0; n_results = 0; starts_cfg = 0; resp_rep = 0;
        pulse_go();
        check(sweep_done_o == 0, "R10 go clears done", sweep_done_o, 0);
        wait_results(3);
        check(res_index_o >= 3 || !res_valid_o, "R2 restart from zero", exp_idx, 3);
        do_reset();
    endtask

    task automatic t_round_stall();
        int s0, guard = 0;
        logic [9:0] a0;
        mode = 2; res_ready_i = 1'b0;
        pulse_go();
        while (!res_valid_o && guard < 20000) begin @(negedge clk); guard++; end
        check(res_valid_o == 1, "R9 beat offered", res_valid_o, 1);
        s0 = n_starts; a0 = res_avg_o;
        repeat (20) @(negedge clk);
        check(res_valid_o == 1, "R9 valid held", res_valid_o, 1);
        check(res_index_o == 0, "R9 index held", res_index_o, 0);
        check(res_avg_o == a0, "R9 avg held", res_avg_o, a0);
        check(n_starts == s0, "R9 no starts while stalled", n_starts, s0);
        res_ready_i = 1'b1;
        wait_results(3);
        do_reset();
    endtask

    initial begin
        t_reset();
        t_full_sweep();
        t_restart_max();
        t_round_stall();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule